// File: doc/BRIEF.md
# Hardware Operand Stack Execution Unit

This block executes zero-address commands against a small register stack. Each command arrives on a valid/ready handshake with an opcode and a memory address. A load command fetches a word from a synchronous data memory and places it on top of the stack. A store command writes the top word to memory and removes it. A unary command rewrites the top word in place. A binary command combines the two top words into one. Instruction fetch and decode are done elsewhere; the unit sees only these commands.

The stack keeps an occupancy count and derives Full and Empty flags from it. Every command is checked against these flags before it runs. A command that would overrun or underrun the stack is rejected and changes no state. It raises a one-cycle error pulse on the overflow or underflow output. Postfix expressions map directly onto the command stream: operands are loaded in order and operators follow them.

Top module: `opstack_unit`

## Requirements
- R1: After a synchronous active-low reset, at any point in operation, `empty` is 1, `full` is 0, both error outputs are 0, the stack holds no entries, and `cmd_ready` is 1.
- R2: A load command (opcode 0) accepted while `full` is 1 is rejected. One cycle after acceptance, `err_overflow` is 1. No memory read occurs and the stack contents are unchanged.
- R3: An accepted load command with `full` at 0 drives `mem_rd_en` with `mem_addr` equal to the command address in the acceptance cycle. It then holds `cmd_ready` low for one cycle. At the end of that cycle, the word returned on `mem_rdata` becomes the new top entry.
- R4: `full` is 1 exactly when the stack holds DEPTH entries. `empty` is 0 after any successful load.
- R5: A store (opcode 1) or shift (opcode 2) command accepted while `empty` is 1 is rejected. One cycle after acceptance, `err_underflow` is 1, and no memory write occurs.
- R6: An accepted store command with `empty` at 0 writes the top entry to the command address in the acceptance cycle and removes that entry. This clears `full`. `empty` becomes 1 when the last entry leaves.
- R7: The shift command replaces the top entry with itself shifted left by one bit within DATA_W bits. The depth does not change.
- R8: Binary commands use opcode 3 (add), 4 (subtract, next-to-top minus top) and 5 (multiply, low DATA_W bits of the product). Each one pops the two top entries and pushes the result, so the depth drops by one.
- R9: A binary command accepted with fewer than two entries is rejected. It pulses `err_underflow` and leaves every entry unchanged.
- R10: Each rejected command produces exactly one cycle of its error output. Neither error output is 1 in a cycle that does not follow an accepted command.
- R11: Opcodes 6 and 7 are accepted and have no effect on the stack, the memory port or the error outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_op | input | 3 | Opcode: 0 load, 1 store, 2 shift left, 3 add, 4 subtract, 5 multiply, 6/7 no operation |
| cmd_addr | input | ADDR_W | Memory address for load and store |
| mem_rd_en | output | 1 | Memory read strobe; data is expected on the next cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the strobe |
| full | output | 1 | Stack holds DEPTH entries |
| empty | output | 1 | Stack holds no entries |
| err_overflow | output | 1 | Pulse after a rejected load |
| err_underflow | output | 1 | Pulse after a rejected store, shift or binary command |

## Verification
The bench builds the unit with DEPTH 4, DATA_W 16 and ADDR_W 8. With a shallow stack, a four-operand postfix expression fills the stack exactly. A fifth load then reaches the overflow path after a few commands. The 16-bit width lets a negative subtraction result and a wrapping shift and multiply be read back through stores. The bench can then observe the full stack, the single-entry binary rejection and the drain to empty at the memory port.

// File: rtl/opstack_pkg.sv
// Shared opcode encoding for the operand stack unit.
// Assumes a 3-bit opcode field; codes 6 and 7 are no-operations.
package opstack_pkg;
    typedef enum logic [2:0] {
        OPC_LOAD  = 3'd0,
        OPC_STORE = 3'd1,
        OPC_SHL   = 3'd2,
        OPC_ADD   = 3'd3,
        OPC_SUB   = 3'd4,
        OPC_MUL   = 3'd5
    } opc_e;
endpackage

// File: rtl/opstack_alu.sv
// Combinational function unit for the operand stack.
// Assumes `nos` is the next-to-top entry and `tos` the top entry;
// unary results use only `tos`.
module opstack_alu #(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] nos,
    input  logic [DATA_W-1:0] tos,
    output logic [DATA_W-1:0] res
);
    import opstack_pkg::*;

    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] prod;

    // Full-width product, truncated below
    always_comb prod = {{DATA_W{1'b0}}, nos} * {{DATA_W{1'b0}}, tos};

    // Select the result for the requested operation
    always_comb begin
        unique case (op)
            OPC_SHL: res = {tos[DATA_W-2:0], 1'b0};
            OPC_ADD: res = nos + tos;
            OPC_SUB: res = nos - tos;
            OPC_MUL: res = prod[DATA_W-1:0];
            default: res = tos;
        endcase
    end
endmodule

// File: rtl/opstack_regfile.sv
// Register stack with occupancy count and Full/Empty flags.
// Assumes the controller never asserts more than one of push/pop/una/bin
// in a cycle and only requests operations the flags allow.
module opstack_regfile #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_en,
    input  logic              una_en,
    input  logic              bin_en,
    input  logic [DATA_W-1:0] alu_res,
    output logic [DATA_W-1:0] tos,
    output logic [DATA_W-1:0] nos,
    output logic              full,
    output logic              empty,
    output logic              has_two
);
    localparam int CNT_W = $clog2(DEPTH + 2);

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] stk [DEPTH];

    // Occupancy count: up on push, down on pop or binary collapse
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (push_en)
            cnt <= cnt + 1'b1;
        else if (pop_en || bin_en)
            cnt <= cnt - 1'b1;
    end

    // One write port per entry, chosen by its position relative to the count
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam logic [CNT_W-1:0] POS0 = CNT_W'(i);
        localparam logic [CNT_W-1:0] POS1 = CNT_W'(i + 1);
        localparam logic [CNT_W-1:0] POS2 = CNT_W'(i + 2);

        // Entry update: new load, in-place unary, or binary result
        always_ff @(posedge clk) begin
            if (!rst_n)
                stk[i] <= '0;
            else if (push_en && cnt == POS0)
                stk[i] <= push_data;
            else if (una_en && cnt == POS1)
                stk[i] <= alu_res;
            else if (bin_en && cnt == POS2)
                stk[i] <= alu_res;
        end
    end

    // Read the two topmost entries by matching the count
    always_comb begin
        tos = '0;
        nos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt == CNT_W'(i + 1)) tos = stk[i];
            if (cnt == CNT_W'(i + 2)) nos = stk[i];
        end
    end

    // Flags derived from the count
    always_comb begin
        full    = (cnt == CNT_W'(DEPTH));
        empty   = (cnt == '0);
        has_two = (cnt >= CNT_W'(2));
    end

    // R4
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> !full);

    // R6
    pop_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |=> !full);
endmodule

// File: rtl/opstack_ctrl.sv
// Command sequencer: checks flags, launches memory accesses, and
// raises registered one-cycle error pulses for rejected commands.
// Assumes memory read data arrives one cycle after mem_rd_en.
module opstack_ctrl #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              full,
    input  logic              empty,
    input  logic              has_two,
    output logic              push_en,
    output logic              pop_en,
    output logic              una_en,
    output logic              bin_en,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              err_overflow,
    output logic              err_underflow
);
    import opstack_pkg::*;

    typedef enum logic {ST_IDLE, ST_FILL} st_e;

    st_e  state;
    logic acc, is_load, is_store, is_shl, is_bin;
    logic ovf_d, udf_d;

    // Decode the command and qualify it against the flags
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        acc       = cmd_valid && cmd_ready;
        is_load   = (cmd_op == OPC_LOAD);
        is_store  = (cmd_op == OPC_STORE);
        is_shl    = (cmd_op == OPC_SHL);
        is_bin    = (cmd_op == OPC_ADD) || (cmd_op == OPC_SUB) || (cmd_op == OPC_MUL);
        mem_rd_en = acc && is_load && !full;
        pop_en    = acc && is_store && !empty;
        mem_wr_en = pop_en;
        una_en    = acc && is_shl && !empty;
        bin_en    = acc && is_bin && has_two;
        push_en   = (state == ST_FILL);
        mem_addr  = cmd_addr;
        ovf_d     = acc && is_load && full;
        udf_d     = acc && (((is_store || is_shl) && empty) || (is_bin && !has_two));
    end

    // Load sequencing: wait one cycle for memory data
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (mem_rd_en)
            state <= ST_FILL;
        else
            state <= ST_IDLE;
    end

    // Error pulses, one per rejected command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_overflow  <= 1'b0;
            err_underflow <= 1'b0;
        end else begin
            err_overflow  <= ovf_d;
            err_underflow <= udf_d;
        end
    end

    // R10
    udf_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |-> $past(cmd_valid && cmd_ready));

    // R2
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |-> $past(cmd_valid && cmd_op == OPC_LOAD && full));

    // R3
    fill_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !cmd_ready);

    // R5
    no_store_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !empty);
endmodule

// File: rtl/opstack_unit.sv
// Top of the zero-address operand stack unit: wires the sequencer,
// register stack and function unit together. Memory write data is
// always the current top entry.
module opstack_unit #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              full,
    output logic              empty,
    output logic              err_overflow,
    output logic              err_underflow
);
    logic              push_en, pop_en, una_en, bin_en, has_two;
    logic [DATA_W-1:0] tos, nos, alu_res;

    opstack_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_op       (cmd_op),
        .cmd_addr     (cmd_addr),
        .full         (full),
        .empty        (empty),
        .has_two      (has_two),
        .push_en      (push_en),
        .pop_en       (pop_en),
        .una_en       (una_en),
        .bin_en       (bin_en),
        .mem_rd_en    (mem_rd_en),
        .mem_wr_en    (mem_wr_en),
        .mem_addr     (mem_addr),
        .err_overflow (err_overflow),
        .err_underflow(err_underflow)
    );

    opstack_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_en),
        .push_data(mem_rdata),
        .pop_en   (pop_en),
        .una_en   (una_en),
        .bin_en   (bin_en),
        .alu_res  (alu_res),
        .tos      (tos),
        .nos      (nos),
        .full     (full),
        .empty    (empty),
        .has_two  (has_two)
    );

    opstack_alu #(.DATA_W(DATA_W)) u_alu (
        .op (cmd_op),
        .nos(nos),
        .tos(tos),
        .res(alu_res)
    );

    // Store data is the top entry
    always_comb mem_wdata = tos;

    // R4
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: tb/test_opstack_unit.sv
module test_opstack_unit;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int DP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          full, empty, err_overflow, err_underflow;

    int   n_chk = 0;
    int   n_bad = 0;
    logic done  = 1'b0;

    logic [DW-1:0] bmem [256];

    always #4 clk = ~clk;

    opstack_unit #(.DATA_W(DW), .DEPTH(DP), .ADDR_W(AW)) i_opstack_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .full(full), .empty(empty),
        .err_overflow(err_overflow), .err_underflow(err_underflow)
    );

    // Synchronous memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= bmem[mem_addr];
        if (mem_wr_en) bmem[mem_addr] <= mem_wdata;
    end

    // Vector: op, addr, exp_ovf, exp_udf, chk_mem, exp_mem
    localparam int NV = 48;
    localparam logic [29:0] VEC [NV] = '{
        {3'd0, 8'd3,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd0, 8'd4,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd5, 8'd0,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd0, 8'd3,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd0, 8'd5,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd0, 8'd4,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd5, 8'd0,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd3, 8'd0,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd4, 8'd0,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd1, 8'd200, 1'b0, 1'b0, 1'b1, 16'hFFF5},
        {3'd1, 8'd210, 1'b0, 1'b1, 1'b1, 16'd210},
        {3'd2, 8'd0,   1'b0, 1'b1, 1'b0, 16'h0000},
        {3'd3, 8'd0,   1'b0, 1'b1, 1'b0, 16'h0000},
        {3'd0, 8'd9,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd3, 8'd0,   1'b0, 1'b1, 1'b0, 16'h0000},
        {3'd1, 8'd201, 1'b0, 1'b0, 1'b1, 16'd9},
        {3'd0, 8'd7,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd2, 8'd0,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd1, 8'd202, 1'b0, 1'b0, 1'b1, 16'd14},
        {3'd0, 8'd6,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd0, 8'd2,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd4, 8'd0,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd1, 8'd203, 1'b0, 1'b0, 1'b1, 16'd4},
        {3'd0, 8'd1,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd0, 8'd2,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd0, 8'd3,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd0, 8'd4,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd0, 8'd5,   1'b1, 1'b0, 1'b0, 16'h0000},
        {3'd1, 8'd204, 1'b0, 1'b0, 1'b1, 16'd4},
        {3'd1, 8'd205, 1'b0, 1'b0, 1'b1, 16'd3},
        {3'd1, 8'd206, 1'b0, 1'b0, 1'b1, 16'd2},
        {3'd1, 8'd207, 1'b0, 1'b0, 1'b1, 16'd1},
        {3'd1, 8'd211, 1'b0, 1'b1, 1'b1, 16'd211},
        {3'd0, 8'd250, 1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd2, 8'd0,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd1, 8'd208, 1'b0, 1'b0, 1'b1, 16'h0002},
        {3'd0, 8'd11,  1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd6, 8'd0,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd7, 8'd212, 1'b0, 1'b0, 1'b1, 16'd212},
        {3'd1, 8'd209, 1'b0, 1'b0, 1'b1, 16'd11},
        {3'd0, 8'd200, 1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd0, 8'd2,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd3, 8'd0,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd1, 8'd213, 1'b0, 1'b0, 1'b1, 16'hFFF7},
        {3'd0, 8'd250, 1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd0, 8'd2,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd5, 8'd0,   1'b0, 1'b0, 1'b0, 16'h0000},
        {3'd1, 8'd214, 1'b0, 1'b0, 1'b1, 16'h0002}
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one command; returns at the falling edge after acceptance
    task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] addr);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = addr;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = DW'(i);
        bmem[250] = 16'h8001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 empty", DW'(empty), 16'd1);
        check("R1 full", DW'(full), 16'd0);
        check("R1 errors", DW'({err_overflow, err_underflow}), 16'd0);
        check("R1 ready", DW'(cmd_ready), 16'd1);

        // Vector walk: R2 R3 R5 R6 R7 R8 R9 R11
        for (int v = 0; v < NV; v++) begin
            run_cmd(VEC[v][29:27], VEC[v][26:19]);
            check("R2 overflow flag", DW'(err_overflow), DW'(VEC[v][18]));
            check("R5/R9 underflow flag", DW'(err_underflow), DW'(VEC[v][17]));
            if (VEC[v][16])
                check("R6/R8 memory word", bmem[VEC[v][26:19]], VEC[v][15:0]);
        end

        // R4 full after DEPTH loads, empty cleared
        @(negedge clk);
        check("R4 empty at start", DW'(empty), 16'd1);
        for (int k = 0; k < DP; k++) run_cmd(3'd0, AW'(20 + k));
        @(negedge clk);
        check("R4 full", DW'(full), 16'd1);
        check("R4 not empty", DW'(empty), 16'd0);
        // R10 single-cycle overflow pulse
        run_cmd(3'd0, 8'd30);
        check("R10 pulse high", DW'(err_overflow), 16'd1);
        @(negedge clk);
        check("R10 pulse low", DW'(err_overflow), 16'd0);
        // R6 store clears full
        run_cmd(3'd1, 8'd215);
        check("R6 full cleared", DW'(full), 16'd0);
        check("R6 stored top", bmem[215], 16'd23);
        // R1 reset with entries present
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 empty after reset", DW'(empty), 16'd1);
        check("R1 full after reset", DW'(full), 16'd0);
        run_cmd(3'd1, 8'd216);
        check("R1 store rejected", DW'(err_underflow), 16'd1);
        check("R1 memory untouched", bmem[216], 16'd216);
        @(negedge clk);
        check("R10 underflow low", DW'(err_underflow), 16'd0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule